// File: doc/BRIEF.md
# Interlaced Grayscale Composite Video Timing Generator

This block generates the timing and the 8-bit output codes for a monochrome, interlaced, 525-line composite video signal. The codes drive an external 8-bit parallel DAC whose full scale stands for 1 V. Each line has four parts: a sync pulse at code 0, a back porch at the black code, an active region that carries the pixel value, and a front porch at the black code. Every duration is a cycle count set by a parameter, so one clock frequency can be chosen for the whole design.

A field holds `VID_LINES` full video lines plus one half line, followed by a vertical sync interval. The interval is eighteen half lines long: six equalizing pulses, six broad serrated pulses, then six equalizing pulses. The interval is the same for both fields. Its position selects the field that comes next:
- At the end of the even field, the last line stops at its midpoint and the interval starts there. The odd field then opens on the second half of a line.
- At the end of the odd field, the interval starts on a whole-line boundary, and the even field that follows opens with a normal sync pulse.

A pixel source reads `active`, `pix_x`, `line_num` and `field_odd`, and returns a grayscale value on `pix_gray` in the same cycle. The block scales that value linearly into the black-to-white code range. The scaled value reaches `dac_code` one clock later.

Top module: `ntsc_gray_timing`

## Requirements
- R1: A synchronous reset (`rst` high) puts the block at line 0 of the even field, at the first cycle of the horizontal sync. While in reset, `dac_code` is 0, `field_odd` is 0, `line_num` is 0 and `active` is 0. After reset is released, the first line begins with `HSYNC_CYC` cycles of code 0.
- R2: A full line produces four runs on `dac_code`, in this order: code 0 for `HSYNC_CYC` cycles, code `BLACK_CODE` for `BPORCH_CYC` cycles, the pixel code for `ACTIVE_CYC` cycles, and code `BLACK_CODE` for `FPORCH_CYC` cycles.
- R3: For every cycle in which `active` is 1, `dac_code` in the following cycle equals `BLACK_CODE + ((pix_gray * (WHITE_CODE - BLACK_CODE + 1)) >> 8)`. With the default codes 77 and 255, gray 0 gives 77, gray 128 gives 166 and gray 255 gives 255. On a full line, `pix_x` is 0 in the first active cycle and rises by one each active cycle.
- R4: `dac_code` only ever holds the sync code 0 or a value from `BLACK_CODE` up to `WHITE_CODE`. Gray 0 maps to black and never to a value below black.
- R5: The even field contains lines 0 to `VID_LINES-1` as full lines. Line `VID_LINES` ends at the midpoint of a line, after `HALF = line period / 2` cycles, and the vertical interval starts right after it.
- R6: Each half line of the vertical interval lasts `HALF` cycles. An equalizing half line is code 0 for `EQ_LOW_CYC` cycles and then black. A broad half line is code 0 for `HALF - SERR_CYC` cycles and then black for `SERR_CYC` cycles. The interval is six equalizing, then six broad, then six equalizing half lines.
- R7: After the interval that follows the even field, the odd field begins at line 0 with the second half of a line: there is no sync pulse, and the active region continues from the midpoint, followed by the front porch. Lines 1 to `VID_LINES` are full lines, and the next interval starts on the line boundary. The even field that follows begins with a normal sync pulse.
- R8: `field_odd` is 0 in the even field and 1 in the odd field. It changes only when a vertical interval ends, and `line_num` is 0 at that moment. During an interval, `field_odd` keeps the value of the field that has just ended.
- R9: `active` is 0 during sync, porches and the whole vertical interval. Whenever `active` is 1, `pix_x` is below `ACTIVE_CYC`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every duration is counted in its cycles |
| rst | input | 1 | Synchronous reset, active high |
| pix_gray | input | 8 | Grayscale value for the current pixel, 0 black to 255 white |
| dac_code | output | 8 | Registered code for the DAC: 0 sync, BLACK_CODE black, WHITE_CODE white |
| active | output | 1 | High while the current cycle is in the active region |
| pix_x | output | $clog2(ACTIVE_CYC) | Column within the active region |
| line_num | output | $clog2(VID_LINES+1) | Line slot within the current field |
| field_odd | output | 1 | 0 for the even field, 1 for the odd field |

## Verification
The hardest case to reach is the pair of field transitions. The even field has to stop halfway through its last line, and the odd field then has to resume from the midpoint with no sync pulse. Both only happen once per field. The bench therefore uses a very short line and a field of only a few lines. It then follows two complete fields and the start of a third as one chain of measured code runs: each run's length is checked against its expected cycle count, and `field_odd` and `line_num` are checked at each transition. A reset applied partway through a field shows that the block restarts cleanly from any state.

// File: rtl/ntsc_gray_timing.sv
module ntsc_gray_timing #(
  parameter int HSYNC_CYC  = 94,
  parameter int BPORCH_CYC = 118,
  parameter int ACTIVE_CYC = 1030,
  parameter int FPORCH_CYC = 28,
  parameter int EQ_LOW_CYC = 46,
  parameter int SERR_CYC   = 94,
  parameter int VID_LINES  = 253,
  parameter int BLACK_CODE = 77,
  parameter int WHITE_CODE = 255
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [7:0]                           pix_gray,
  output logic [7:0]                           dac_code,
  output logic                                 active,
  output logic [$clog2(ACTIVE_CYC)-1:0]        pix_x,
  output logic [$clog2(VID_LINES+1)-1:0]       line_num,
  output logic                                 field_odd
);
  localparam int LINE_CYC = HSYNC_CYC + BPORCH_CYC + ACTIVE_CYC + FPORCH_CYC;
  localparam int HALF_CYC = LINE_CYC / 2;
  localparam int HW       = $clog2(LINE_CYC);
  localparam int LW       = $clog2(VID_LINES + 1);
  localparam int XW       = $clog2(ACTIVE_CYC);
  localparam int SPAN     = WHITE_CODE - BLACK_CODE + 1;

  localparam logic [HW-1:0] H_SYNC_END  = HW'(HSYNC_CYC);
  localparam logic [HW-1:0] H_VIS_START = HW'(HSYNC_CYC + BPORCH_CYC);
  localparam logic [HW-1:0] H_VIS_END   = HW'(HSYNC_CYC + BPORCH_CYC + ACTIVE_CYC);
  localparam logic [HW-1:0] H_HALF      = HW'(HALF_CYC);
  localparam logic [HW-1:0] H_HALF_LAST = HW'(HALF_CYC - 1);
  localparam logic [HW-1:0] H_LINE_LAST = HW'(LINE_CYC - 1);
  localparam logic [HW-1:0] H_EQ_END    = HW'(EQ_LOW_CYC);
  localparam logic [HW-1:0] H_BROAD_END = HW'(HALF_CYC - SERR_CYC);
  localparam logic [LW-1:0] LAST_SLOT   = LW'(VID_LINES);
  localparam logic [7:0]    C_BLACK     = 8'(BLACK_CODE);

  logic [HW-1:0] hcnt;
  logic [LW-1:0] line_q;
  logic          field_q;
  logic          in_vs;
  logic [4:0]    vs_idx;
  logic [7:0]    dac_q;

  logic          last_slot, short_line, line_end, vs_done;
  logic          broad, sync_low, vid_on;
  logic [15:0]   prod;
  logic [7:0]    code_nxt;

  assign last_slot  = (line_q == LAST_SLOT);
  assign short_line = in_vs || (!field_q && last_slot);
  assign line_end   = short_line ? (hcnt == H_HALF_LAST) : (hcnt == H_LINE_LAST);
  assign vs_done    = in_vs && (vs_idx == 5'd17) && line_end;

  assign broad    = (vs_idx >= 5'd6) && (vs_idx < 5'd12);
  assign sync_low = in_vs ? (broad ? (hcnt < H_BROAD_END) : (hcnt < H_EQ_END))
                          : (hcnt < H_SYNC_END);
  assign vid_on   = !in_vs && (hcnt >= H_VIS_START) && (hcnt < H_VIS_END);

  assign prod     = {8'd0, pix_gray} * 16'(SPAN);
  assign code_nxt = sync_low ? 8'd0 : (vid_on ? C_BLACK + prod[15:8] : C_BLACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt    <= '0;
      line_q  <= '0;
      field_q <= 1'b0;
      in_vs   <= 1'b0;
      vs_idx  <= '0;
      dac_q   <= '0;
    end else begin
      dac_q <= code_nxt;
      if (line_end) begin
        hcnt <= (vs_done && !field_q) ? H_HALF : '0;
        if (vs_done) begin
          in_vs   <= 1'b0;
          field_q <= ~field_q;
          line_q  <= '0;
        end else if (in_vs) begin
          vs_idx <= vs_idx + 1'b1;
        end else if (last_slot) begin
          in_vs  <= 1'b1;
          vs_idx <= '0;
        end else begin
          line_q <= line_q + 1'b1;
        end
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  assign dac_code  = dac_q;
  assign active    = vid_on;
  assign pix_x     = vid_on ? XW'(hcnt - H_VIS_START) : '0;
  assign line_num  = line_q;
  assign field_odd = field_q;
endmodule

// File: rtl/ntsc_gray_timing_chk.sv
module ntsc_gray_timing_chk #(
  parameter int ACTIVE_CYC = 1030,
  parameter int VID_LINES  = 253,
  parameter int BLACK_CODE = 77
) (
  input logic                              clk,
  input logic                              rst,
  input logic [7:0]                        pix_gray,
  input logic [7:0]                        dac_code,
  input logic                              active,
  input logic [$clog2(ACTIVE_CYC)-1:0]     pix_x,
  input logic [$clog2(VID_LINES+1)-1:0]    line_num,
  input logic                              field_odd
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (dac_code == 8'd0 && !field_odd && line_num == '0 && !active)); // R1

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (dac_code == 8'd0) || (int'(dac_code) >= BLACK_CODE)); // R4

  AST_ACTIVE_NOT_SYNC: assert property (@(posedge clk) disable iff (rst)
    active |=> (int'(dac_code) >= BLACK_CODE)); // R3

  AST_PIX_STEP: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active)) |-> (int'(pix_x) == int'($past(pix_x)) + 1)); // R3

  AST_FIELD_AT_LINE0: assert property (@(posedge clk) disable iff (rst)
    !$stable(field_odd) |-> (line_num == '0)); // R8

  AST_PIX_RANGE: assert property (@(posedge clk) disable iff (rst)
    active |-> (int'(pix_x) < ACTIVE_CYC)); // R9
endmodule

bind ntsc_gray_timing ntsc_gray_timing_chk #(
  .ACTIVE_CYC(ACTIVE_CYC),
  .VID_LINES (VID_LINES),
  .BLACK_CODE(BLACK_CODE)
) u_chk (.*);

// File: tb/tb_ntsc_gray_timing.sv
module tb_ntsc_gray_timing;
  localparam int HS = 4, BP = 5, ACT = 20, FP = 3, EQ = 2, SERR = 4, NL = 5;
  localparam int HALF = (HS + BP + ACT + FP) / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] pix_gray = 8'd255;
  logic [7:0] dac_code;
  logic active, field_odd;
  logic [$clog2(ACT)-1:0] pix_x;
  logic [$clog2(NL+1)-1:0] line_num;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  ntsc_gray_timing #(
    .HSYNC_CYC(HS), .BPORCH_CYC(BP), .ACTIVE_CYC(ACT), .FPORCH_CYC(FP),
    .EQ_LOW_CYC(EQ), .SERR_CYC(SERR), .VID_LINES(NL),
    .BLACK_CODE(77), .WHITE_CODE(255)
  ) dut (.*);

  // {gray in, expected code}
  localparam logic [15:0] VEC [8] = '{
    {8'd0,   8'd77},  {8'd255, 8'd255}, {8'd128, 8'd166}, {8'd64,  8'd121},
    {8'd1,   8'd77},  {8'd2,   8'd78},  {8'd200, 8'd216}, {8'd254, 8'd254}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_len(input logic [7:0] code, input int len, input string tag);
    int n = 0;
    while (dac_code == code && n < 5000) begin
      n++;
      @(negedge clk);
    end
    check(n == len, tag, n, len);
  endtask

  task automatic full_line();
    run_len(8'd0,   HS,  "R2 hsync length");
    run_len(8'd77,  BP,  "R2 back porch length");
    run_len(8'd255, ACT, "R2 active length");
    run_len(8'd77,  FP,  "R2 front porch length");
  endtask

  task automatic vsync_block();
    check(!active, "R9 active low in vertical interval", active, 0);
    for (int i = 0; i < 6; i++) begin
      run_len(8'd0,  EQ,        "R6 equalizing low");
      run_len(8'd77, HALF - EQ, "R6 equalizing black");
    end
    for (int i = 0; i < 6; i++) begin
      run_len(8'd0,  HALF - SERR, "R6 broad low");
      run_len(8'd77, SERR,        "R6 serration");
    end
    for (int i = 0; i < 6; i++) begin
      run_len(8'd0,  EQ,        "R6 equalizing low");
      run_len(8'd77, HALF - EQ, "R6 equalizing black");
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(dac_code == 8'd0, "R1 reset code", dac_code, 0);
    check(!field_odd, "R1 reset field", field_odd, 0);
    check(line_num == 0, "R1 reset line", line_num, 0);
    check(!active, "R1 reset active", active, 0);
    rst = 1'b0;
    @(negedge clk);

    check(!field_odd, "R8 even field first", field_odd, 0);
    for (int l = 0; l < NL; l++) full_line();
    check(line_num == NL, "R5 last slot number", line_num, NL);
    run_len(8'd0,   HS,             "R5 half line hsync");
    run_len(8'd77,  BP,             "R5 half line back porch");
    run_len(8'd255, HALF - HS - BP, "R5 half line active stops at midpoint");
    check(!field_odd, "R8 field held during interval", field_odd, 0);
    vsync_block();
    check(field_odd, "R8 odd after mid-line interval", field_odd, 1);
    check(line_num == 0, "R7 odd field line 0", line_num, 0);
    run_len(8'd255, HS + BP + ACT - HALF, "R7 second half active");
    run_len(8'd77,  FP,                   "R7 second half front porch");
    for (int l = 0; l < NL; l++) full_line();
    check(field_odd, "R8 odd field held into interval", field_odd, 1);
    vsync_block();
    check(!field_odd, "R8 even after boundary interval", field_odd, 0);
    check(line_num == 0, "R7 even field restarts line 0", line_num, 0);
    full_line();

    for (int v = 0; v < 8; v++) begin
      while (active) @(negedge clk);
      pix_gray = VEC[v][15:8];
      while (!active) @(negedge clk);
      @(negedge clk);
      check(dac_code == VEC[v][7:0], "R3 and R4 gray scaling", dac_code, VEC[v][7:0]);
    end

    while (!(active && !field_odd && line_num == 1)) @(negedge clk);
    while (active) @(negedge clk);
    while (!active) @(negedge clk);
    check(pix_x == 0, "R3 first column", pix_x, 0);
    begin
      int n = 0;
      int last = 0;
      while (active && n < 1000) begin
        last = pix_x;
        n++;
        @(negedge clk);
      end
      check(n == ACT, "R9 active strobe width", n, ACT);
      check(last == ACT - 1, "R3 last column", last, ACT - 1);
    end

    repeat (37) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(dac_code == 8'd0 && !field_odd && line_num == 0 && !active,
          "R1 mid-run reset state", dac_code, 0);
    rst = 1'b0;
    @(negedge clk);
    run_len(8'd0,  HS, "R1 hsync after reset");
    run_len(8'd77, BP, "R1 back porch after reset");

    summary();
    $finish;
  end
endmodule